// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog. It has a 32-bit down-counter that is clocked by the peripheral clock. Its period is a power of two, 2^(BASE_EXP + e) cycles, where the exponent e is a 4-bit field. There are two separate exponents. The first applies only to the period that follows enabling. The second applies to every later reload. Software keeps the system alive by writing a fixed key to the restart register. Any other value written to that register is ignored. Once the watchdog is enabled, software cannot turn it off. Only the block's own reset input returns it to the disabled state.

When the counter expires, the block responds in one of two ways, chosen by a mode bit. In direct mode it issues a system-reset pulse of fixed length. In warn-first mode the first expiry raises an interrupt and reloads the counter. A second expiry while that interrupt is still pending issues the reset pulse. The interrupt is cleared by reading a dedicated clear address.

The control is a four-state machine:
- OFF: disabled, the counter is held.
- RUN: counting.
- WARN: counting with the interrupt pending.
- BITE: the reset pulse is being driven.

Its transitions are:
- enable: OFF to RUN, loading the initial period.
- restart: in RUN or WARN, the key reloads the main period.
- warn: RUN to WARN on expiry in warn-first mode, reloading the main period.
- bite: RUN to BITE on expiry in direct mode, or WARN to BITE on expiry.
- ack: WARN to RUN when the clear address is read.
- recover: BITE to RUN after the pulse, reloading the main period.
- Any state returns to OFF on block reset.

Top module: `wdog_top`

## Requirements
- R1: After reset, address 0x00 reads 0, the counter (address 0x08) reads 0, and both irq and sys_rst are low.
- R2: Writing a value with bit 0 set to 0x00 enables the block. The counter is then loaded with 2^(BASE_EXP+ie)-1, where ie is bits [7:4] of the range register at 0x04. The counter value reads back at 0x08, and the enable reads back at bit 0 of 0x00.
- R3: Once the block is enabled, writes to 0x00 cannot clear bit 0. Bit 1 (mode: 0 = direct reset, 1 = warn first) takes a written value only while the block is disabled, which includes the enabling write itself.
- R4: The counter decreases by one each cycle. Expiry occurs exactly P cycles after a load of P-1.
- R5: Writing exactly 0x76 to 0x0C while counting reloads the counter with 2^(BASE_EXP+me)-1, where me is bits [3:0] of 0x04. If the restart write falls in the same cycle as an expiry, the restart wins.
- R6: A write of any other value to 0x0C leaves the counter unchanged.
- R7: In direct mode, expiry asserts sys_rst.
- R8: sys_rst stays high for exactly 8 cycles. The counter then holds 2^(BASE_EXP+me)-1 and keeps counting, with irq low.
- R9: In warn-first mode, the first expiry raises irq, sets bit 0 of 0x10, and reloads the main period.
- R10: A read strobe at 0x14 clears irq. The next expiry then raises irq again instead of resetting.
- R11: An expiry while irq is pending asserts sys_rst. A clearing read in that same cycle does not prevent it.
- R12: The block reset input returns the block to the disabled state from any state, and no later expiry occurs.
- R13: irq and sys_rst are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| addr | input | ADDR_W | Register byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; needed only for the clearing read at 0x14 |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for addr |
| irq | output | 1 | Warning interrupt |
| sys_rst | output | 1 | System reset pulse |

## Verification
Every register write and every clearing read takes effect on the clock edge that samples it. Each result is therefore due at a fixed point after its stimulus:
- A reload shows up on the counter readback in the cycle right after the write.
- An expiry state change lands P edges after the load edge.
- The reset pulse lasts exactly eight edges.

The bench keeps a free-running edge count and stamps each load, and each irq or sys_rst rise, with it. It then compares the stamps against load time plus the period computed from the exponents. For the same-cycle corner cases, it times the key write and the clearing read to the exact expiry edge using that count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_RUN  = 2'd1,
        S_WARN = 2'd2,
        S_BITE = 2'd3
    } wd_state_t;

    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_RANGE   = 'h04;
    localparam int OFS_COUNT   = 'h08;
    localparam int OFS_RESTART = 'h0C;
    localparam int OFS_ISTAT   = 'h10;
    localparam int OFS_ICLR    = 'h14;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int EXP_W  = 4,
    parameter int KEY    = 'h76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              en,
    input  logic              irq,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rdata,
    output logic              mode,
    output logic [EXP_W-1:0]  init_exp,
    output logic [EXP_W-1:0]  main_exp,
    output logic              en_req,
    output logic              key_hit,
    output logic              irq_clr
);
    import wdog_pkg::*;

    localparam int RANGE_W = 2 * EXP_W;

    logic [RANGE_W-1:0] range_q;
    logic sel_ctrl, sel_range, sel_count, sel_restart, sel_istat, sel_iclr;

    always_comb begin
        sel_ctrl    = (addr == ADDR_W'(OFS_CTRL));
        sel_range   = (addr == ADDR_W'(OFS_RANGE));
        sel_count   = (addr == ADDR_W'(OFS_COUNT));
        sel_restart = (addr == ADDR_W'(OFS_RESTART));
        sel_istat   = (addr == ADDR_W'(OFS_ISTAT));
        sel_iclr    = (addr == ADDR_W'(OFS_ICLR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode    <= 1'b0;
            range_q <= '0;
        end else if (wr_en) begin
            if (sel_ctrl && !en)
                mode <= wdata[1];
            if (sel_range)
                range_q <= wdata[RANGE_W-1:0];
        end
    end

    always_comb begin
        main_exp = range_q[EXP_W-1:0];
        init_exp = range_q[RANGE_W-1:EXP_W];
        en_req   = wr_en && sel_ctrl && wdata[0];
        key_hit  = wr_en && sel_restart && (wdata == DATA_W'(KEY));
        irq_clr  = rd_en && sel_iclr;
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl)
            rdata = DATA_W'({mode, en});
        else if (sel_range)
            rdata = DATA_W'(range_q);
        else if (sel_count)
            rdata = DATA_W'(cnt);
        else if (sel_istat || sel_iclr)
            rdata = DATA_W'(irq);
    end

    // R3
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(mode));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W    = 32,
    parameter int BASE_EXP = 16,
    parameter int EXP_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_init,
    input  logic             load_main,
    input  logic             run,
    input  logic [EXP_W-1:0] init_exp,
    input  logic [EXP_W-1:0] main_exp,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    localparam int MAX_EXP = BASE_EXP + (1 << EXP_W) - 1;

    function automatic logic [CNT_W-1:0] span_m1(input logic [EXP_W-1:0] e);
        return (CNT_W'(1) << (BASE_EXP + int'(e))) - CNT_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_init)
            cnt <= span_m1(init_exp);
        else if (load_main)
            cnt <= span_m1(main_exp);
        else if (run && cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    always_comb zero = (cnt == '0);

    // R2
    initial width_fit_chk: assert (MAX_EXP < CNT_W);

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load_init && !load_main |=> $stable(cnt));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm #(
    parameter int PULSE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic key_hit,
    input  logic irq_clr,
    input  logic zero,
    input  logic mode,
    output logic load_init,
    output logic load_main,
    output logic run,
    output logic en,
    output logic irq,
    output logic sys_rst
);
    import wdog_pkg::*;

    localparam int PW = $clog2(PULSE + 1);

    wd_state_t state, nxt;
    logic [PW-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_OFF;
            pcnt  <= '0;
        end else begin
            state <= nxt;
            pcnt  <= (state == S_BITE) ? pcnt + PW'(1) : '0;
        end
    end

    always_comb begin
        nxt       = state;
        load_init = 1'b0;
        load_main = 1'b0;
        unique case (state)
            S_OFF: begin
                if (en_req) begin
                    nxt       = S_RUN;
                    load_init = 1'b1;
                end
            end
            S_RUN: begin
                if (key_hit) begin
                    load_main = 1'b1;
                end else if (zero) begin
                    load_main = mode;
                    nxt       = mode ? S_WARN : S_BITE;
                end
            end
            S_WARN: begin
                if (key_hit) begin
                    load_main = 1'b1;
                    if (irq_clr)
                        nxt = S_RUN;
                end else if (zero) begin
                    nxt = S_BITE;
                end else if (irq_clr) begin
                    nxt = S_RUN;
                end
            end
            S_BITE: begin
                if (pcnt == PW'(PULSE - 1)) begin
                    nxt       = S_RUN;
                    load_main = 1'b1;
                end
            end
            default: nxt = S_OFF;
        endcase
    end

    always_comb begin
        en      = (state != S_OFF);
        run     = (state == S_RUN) || (state == S_WARN);
        irq     = (state == S_WARN);
        sys_rst = (state == S_BITE);
    end

    // R3
    sticky_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

    // R7
    bite_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(zero));

    // R8
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |=> sys_rst);

    // R9
    irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mode);

    // R13
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq, sys_rst}));

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 32,
    parameter int EXP_W    = 4,
    parameter int BASE_EXP = 16,
    parameter int PULSE    = 8,
    parameter int KEY      = 'h76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              sys_rst
);
    logic             mode, en, en_req, key_hit, irq_clr;
    logic             load_init, load_main, run, zero;
    logic [EXP_W-1:0] init_exp, main_exp;
    logic [CNT_W-1:0] cnt;

    wdog_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .EXP_W(EXP_W), .KEY(KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .en(en), .irq(irq), .cnt(cnt),
        .rdata(rdata), .mode(mode), .init_exp(init_exp),
        .main_exp(main_exp), .en_req(en_req), .key_hit(key_hit),
        .irq_clr(irq_clr)
    );

    wdog_counter #(
        .CNT_W(CNT_W), .BASE_EXP(BASE_EXP), .EXP_W(EXP_W)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_init(load_init),
        .load_main(load_main), .run(run), .init_exp(init_exp),
        .main_exp(main_exp), .cnt(cnt), .zero(zero)
    );

    wdog_fsm #(
        .PULSE(PULSE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .key_hit(key_hit),
        .irq_clr(irq_clr), .zero(zero), .mode(mode),
        .load_init(load_init), .load_main(load_main), .run(run),
        .en(en), .irq(irq), .sys_rst(sys_rst)
    );

    // R5
    key_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit && run |=> !$rose(sys_rst) && !$rose(irq) && (cnt != '0 || BASE_EXP == 0));

endmodule

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;

    localparam int B = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sys_rst;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;

    wdog_top #(.BASE_EXP(B)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst(sys_rst)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int per(input int e);
        return 1 << (B + e);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_clr();
        addr = 8'h14; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_sig(input bit want_irq, output int t);
        int n = 0;
        while (((want_irq ? irq : sys_rst) !== 1'b1) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v, c0;
        int t0, t1, t2, len;
        void'($urandom(32'd2024));

        @(negedge clk);
        do_reset();

        // R1 reset state
        peek(8'h00, v); check("R1 ctrl", v, 0);
        peek(8'h08, v); check("R1 count", v, 0);
        check("R1 irq", irq, 0);
        check("R1 sys_rst", sys_rst, 0);

        // R2 enable loads initial period (ie=2, me=1)
        wr(8'h04, 32'h21);
        wr(8'h00, 32'h1);
        t0 = cyc;
        peek(8'h08, v); check("R2 init load", v, per(2) - 1);
        peek(8'h00, v); check("R2 enable readback", v, 1);

        // R3 enable sticky, mode locked
        wr(8'h00, 32'h0);
        peek(8'h00, v); check("R3 clear ignored", v, 1);
        wr(8'h00, 32'h2);
        peek(8'h00, v); check("R3 mode locked", v, 1);

        // R6 wrong key ignored
        peek(8'h08, c0);
        wr(8'h0C, 32'h77);
        peek(8'h08, v); check("R6 wrong key", v, c0 - 1);
        peek(8'h08, c0);
        wr(8'h0C, 32'h176);
        peek(8'h08, v); check("R6 wide wrong key", v, c0 - 1);

        // R4 R7 direct-mode expiry time
        wait_sig(1'b0, t1);
        check("R7 bite time", t1, t0 + per(2));
        check("R13 irq low in bite", irq, 0);

        // R8 pulse length and reload
        len = 0;
        while (sys_rst === 1'b1 && len < 100) begin @(negedge clk); len++; end
        check("R8 pulse length", len, 8);
        peek(8'h08, v); check("R8 reload main", v, per(1) - 1);
        check("R8 irq low", irq, 0);

        // R5 restart in the expiry cycle wins
        peek(8'h08, v);
        while (v != 0) begin @(negedge clk); peek(8'h08, v); end
        wr(8'h0C, 32'h76);
        t2 = cyc;
        check("R5 no bite on key at expiry", sys_rst, 0);
        peek(8'h08, v); check("R5 key reload", v, per(1) - 1);
        wait_sig(1'b0, t1);
        check("R4 period after key", t1, t2 + per(1));

        // R12 block reset stops it
        do_reset();
        peek(8'h00, v); check("R12 ctrl cleared", v, 0);
        peek(8'h08, v); check("R12 count cleared", v, 0);
        repeat (300) @(negedge clk);
        check("R12 no bite after reset", sys_rst, 0);

        // R9 warn-first mode (ie=1, me=0)
        wr(8'h04, 32'h10);
        wr(8'h00, 32'h3);
        t0 = cyc;
        peek(8'h00, v); check("R3 mode set on enabling write", v, 3);
        wait_sig(1'b1, t1);
        check("R9 irq time", t1, t0 + per(1));
        check("R9 no reset on first expiry", sys_rst, 0);
        peek(8'h10, v); check("R9 status bit", v, 1);
        peek(8'h08, v); check("R9 reload main", v, per(0) - 1);

        // R10 clear and re-raise
        rd_clr();
        check("R10 irq cleared", irq, 0);
        wait_sig(1'b1, t2);
        check("R10 second warn", t2, t1 + per(0));

        // R11 clear in the same cycle as expiry does not save it
        while (cyc != t2 + per(0) - 1) @(negedge clk);
        rd_clr();
        check("R11 bite despite clear", sys_rst, 1);
        check("R11 bite time", cyc, t2 + per(0));

        // random runs
        for (int it = 0; it < 14; it++) begin
            int ie, me, md, nr, pc, tl, g, te;
            ie = $urandom % 4; me = $urandom % 4; md = $urandom % 2;
            do_reset();
            wr(8'h04, (ie << 4) | me);
            wr(8'h00, (md << 1) | 1);
            tl = cyc; pc = per(ie);
            nr = $urandom % 4;
            for (int k = 0; k < nr; k++) begin
                g = 1 + ($urandom % (pc / 2));
                repeat (g) @(negedge clk);
                if ($urandom % 2 == 1) begin
                    logic [31:0] w;
                    w = $urandom;
                    if (w == 32'h76) w = 32'h75;
                    wr(8'h0C, w);
                end
                wr(8'h0C, 32'h76);
                tl = cyc; pc = per(me);
            end
            if (md == 0) begin
                wait_sig(1'b0, te);
                check("R7 random bite", te, tl + pc);
            end else begin
                wait_sig(1'b1, te);
                check("R9 random warn", te, tl + pc);
                wait_sig(1'b0, t1);
                check("R11 random bite", t1, te + per(me));
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule